// File: doc/BRIEF.md
# Peripheral Port Strobe Timing Controller

This block produces the select, address-strobe and write-enable timing for a simple external I/O port that sits on a shared ROM/Flash-style bus. A transfer request carries its direction, a data bus width code and a beat count. The controller then opens a chip-select window that is long enough for every beat. Inside that window it places one address-strobe pulse, positioned by two programmable fields: a lead time and a width. On writes it drives a write enable. After the window closes, it holds chip select low for a minimum recovery time, and that time depends on bus width and direction.

Three programming fields set the timing: `cfg_lead` (strobe delay), `cfg_width` (strobe length) and `cfg_lat` (per-beat access latency). A combinational flag reports when the strobe fields do not fit the latency budget of the selected bus width. The controller is a three-state machine:

- **IDLE**: `req_ready` is high. A valid request moves the machine to ACCESS.
- **ACCESS**: chip select is asserted. The last cycle of the last beat moves the machine to RECOVER.
- **RECOVER**: chip select is negated and requests are held off. When the recovery count expires, the machine returns to IDLE.

Top module: `pxs_strobe_ctrl`

## Requirements
- R1: After reset, `port_cs`, `port_as`, `port_we`, `beat_o`, `done_o` are 0 and `req_ready` is 1. With all programming fields 0, `cfg_err` is 0.
- R2: A request accepted on a clock edge raises `port_cs` on the next cycle (window cycle 0). `port_as` rises in window cycle `cfg_lead` and stays high for exactly `cfg_width` cycles.
- R3: With `cfg_width` = 0, `port_as` stays low for the whole transfer.
- R4: `req_beats` encodes the beat count minus one. Each beat lasts `cfg_lat`+2 cycles. `port_cs` stays high for beats×(`cfg_lat`+2) consecutive cycles. The strobe fires only once per transfer, whatever the beat count.
- R5: `beat_o` pulses on the last cycle of every beat. `done_o` pulses together with the last beat's pulse and at no other time.
- R6: `port_we` is high only on write transfers, only while `port_cs` is high, and in every window cycle except the first cycle of each beat.
- R7: Width code 2'b00 selects an 8-bit bus, 2'b01 a 32-bit bus, and 2'b10/2'b11 a 64-bit bus. After an 8-bit read or any write, `port_cs` stays low at least 5 cycles. After a 32/64-bit read, it stays low at least 2 cycles. `req_ready` is low during that interval except its final cycle.
- R8: `cfg_err` is 1 exactly when `cfg_lead`+`cfg_width` exceeds `cfg_lat`+7 (with width code 2'b00) or `cfg_lat`+4 (otherwise).
- R9: With `cfg_lead` = 0 and `cfg_width` at its largest legal value for the bus width, back-to-back transfers keep `port_as` high without a gap across the chip-select recovery interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Bus width code (00 = 8, 01 = 32, 1x = 64 bit) |
| req_beats | input | BEAT_W | Beat count minus one |
| cfg_lead | input | CFG_W | Strobe delay from first select cycle |
| cfg_width | input | CFG_W | Strobe active length, 0 disables |
| cfg_lat | input | CFG_W | Access latency; beat length is this plus 2 |
| req_ready | output | 1 | Request accepted when high with req_valid |
| port_cs | output | 1 | Chip select, active high |
| port_as | output | 1 | Address strobe, active high |
| port_we | output | 1 | Write enable, active high |
| beat_o | output | 1 | Last cycle of a data beat |
| done_o | output | 1 | Last cycle of the transfer |
| cfg_err | output | 1 | Illegal strobe programming |

## Verification
Several single-beat and multi-beat transfers exercise the strobe placement:

- A 32-bit read with a nonzero lead separates a correct delay from an off-by-one start.
- A 4-beat 64-bit read shows whether the strobe repeats per beat.
- An 8-bit write contrasts the long recovery time with the short one used after wide reads, and exposes the write-enable gaps at beat starts.
- A transfer with zero strobe width confirms the strobe can be disabled.

Legality is probed just on each side of both limits. Two back-to-back pairs at the maximal strobe width, one wide and one narrow, show whether the strobe bridges the recovery gap.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RECOVER = 2'd2
    } pxs_state_e;

    localparam logic [1:0] BUS_8BIT = 2'b00;
endpackage

// File: rtl/pxs_cfg_chk.sv
module pxs_cfg_chk #(
    parameter int CFG_W        = 4,
    parameter int NARROW_SLACK = 7,
    parameter int WIDE_SLACK   = 4
) (
    input  logic [CFG_W-1:0] cfg_lead,
    input  logic [CFG_W-1:0] cfg_width,
    input  logic [CFG_W-1:0] cfg_lat,
    input  logic             narrow,
    output logic             err
);
    localparam int SUM_W = CFG_W + 2;

    logic [SUM_W-1:0] used;
    logic [SUM_W-1:0] budget;

    always_comb begin
        used   = SUM_W'(cfg_lead) + SUM_W'(cfg_width);
        budget = SUM_W'(cfg_lat) + (narrow ? SUM_W'(NARROW_SLACK) : SUM_W'(WIDE_SLACK));
        err    = used > budget;
    end
endmodule

// File: rtl/pxs_as_gen.sv
module pxs_as_gen #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CFG_W-1:0] cfg_lead,
    input  logic [CFG_W-1:0] cfg_width,
    output logic             as_o
);
    logic [CFG_W-1:0] dly_q;
    logic [CFG_W-1:0] hi_q;
    logic [CFG_W-1:0] wid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            hi_q  <= '0;
            wid_q <= '0;
        end else if (start_i) begin
            wid_q <= cfg_width;
            if (cfg_width == '0) begin
                dly_q <= '0;
                hi_q  <= '0;
            end else if (cfg_lead == '0) begin
                dly_q <= '0;
                hi_q  <= cfg_width;
            end else begin
                dly_q <= cfg_lead;
                hi_q  <= '0;
            end
        end else if (dly_q != '0) begin
            dly_q <= dly_q - CFG_W'(1);
            if (dly_q == CFG_W'(1)) hi_q <= wid_q;
        end else if (hi_q != '0) begin
            hi_q <= hi_q - CFG_W'(1);
        end
    end

    always_comb as_o = (hi_q != '0);

    // R3: a disabled strobe never appears after the transfer start
    p_as_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (cfg_width == '0) |=> !as_o);

    // R2: zero lead with nonzero width raises the strobe in the first select cycle
    p_as_lead0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (cfg_lead == '0) && (cfg_width != '0) |=> as_o);
endmodule

// File: rtl/pxs_seq.sv
module pxs_seq
    import pxs_pkg::*;
#(
    parameter int CFG_W      = 4,
    parameter int BEAT_W     = 2,
    parameter int GAP_NARROW = 5,
    parameter int GAP_WIDE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_width,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [CFG_W-1:0]  cfg_lat,
    output logic              req_ready,
    output logic              start_o,
    output logic              cs_o,
    output logic              we_o,
    output logic              beat_o,
    output logic              done_o
);
    localparam int GAP_MAX = (GAP_NARROW > GAP_WIDE) ? GAP_NARROW : GAP_WIDE;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int CYC_W   = CFG_W + 1;

    pxs_state_e        state_q, state_d;
    logic [CYC_W-1:0]  cyc_q;
    logic [BEAT_W-1:0] beat_q, last_q;
    logic [CFG_W-1:0]  lat_q;
    logic              wr_q, narrow_q;
    logic [GAP_W-1:0]  gap_q;

    logic beat_end, last_beat, accept;
    logic [GAP_W-1:0] gap_load;

    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid;
        beat_end  = (state_q == ST_ACCESS) && (cyc_q == (CYC_W'(lat_q) + CYC_W'(1)));
        last_beat = beat_end && (beat_q == last_q);
        gap_load  = (narrow_q || wr_q) ? GAP_W'(GAP_NARROW - 1) : GAP_W'(GAP_WIDE - 1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ACCESS;
            ST_ACCESS:  if (last_beat) state_d = ST_RECOVER;
            ST_RECOVER: if (gap_q == GAP_W'(1)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q    <= '0;
            beat_q   <= '0;
            last_q   <= '0;
            lat_q    <= '0;
            wr_q     <= 1'b0;
            narrow_q <= 1'b0;
            gap_q    <= '0;
        end else if (accept) begin
            cyc_q    <= '0;
            beat_q   <= '0;
            last_q   <= req_beats;
            lat_q    <= cfg_lat;
            wr_q     <= req_write;
            narrow_q <= (req_width == BUS_8BIT);
        end else if (state_q == ST_ACCESS) begin
            if (beat_end) begin
                cyc_q  <= '0;
                beat_q <= beat_q + BEAT_W'(1);
                if (last_beat) gap_q <= gap_load;
            end else begin
                cyc_q <= cyc_q + CYC_W'(1);
            end
        end else if (state_q == ST_RECOVER) begin
            gap_q <= gap_q - GAP_W'(1);
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        start_o   = accept;
        cs_o      = (state_q == ST_ACCESS);
        we_o      = (state_q == ST_ACCESS) && wr_q && (cyc_q != '0);
        beat_o    = beat_end;
        done_o    = last_beat;
    end

    // R6: write enable only inside the select window
    p_we_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> cs_o);

    // R5: completion only with a beat pulse
    p_done_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> beat_o && cs_o);

    // R7: select never reasserts in the cycle after it drops
    p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |=> !cs_o);

    // R7: requests held off while recovering
    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> !req_ready);

    // R4: the select window stays open until the transfer completes
    p_cs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o && !done_o |=> cs_o);
endmodule

// File: rtl/pxs_strobe_ctrl.sv
module pxs_strobe_ctrl #(
    parameter int CFG_W  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_width,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [CFG_W-1:0]  cfg_lead,
    input  logic [CFG_W-1:0]  cfg_width,
    input  logic [CFG_W-1:0]  cfg_lat,
    output logic              req_ready,
    output logic              port_cs,
    output logic              port_as,
    output logic              port_we,
    output logic              beat_o,
    output logic              done_o,
    output logic              cfg_err
);
    logic start;

    pxs_seq #(
        .CFG_W     (CFG_W),
        .BEAT_W    (BEAT_W),
        .GAP_NARROW(5),
        .GAP_WIDE  (2)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_width(req_width),
        .req_beats(req_beats),
        .cfg_lat  (cfg_lat),
        .req_ready(req_ready),
        .start_o  (start),
        .cs_o     (port_cs),
        .we_o     (port_we),
        .beat_o   (beat_o),
        .done_o   (done_o)
    );

    pxs_as_gen #(.CFG_W(CFG_W)) u_as (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cfg_lead (cfg_lead),
        .cfg_width(cfg_width),
        .as_o     (port_as)
    );

    pxs_cfg_chk #(
        .CFG_W       (CFG_W),
        .NARROW_SLACK(7),
        .WIDE_SLACK  (4)
    ) u_chk (
        .cfg_lead (cfg_lead),
        .cfg_width(cfg_width),
        .cfg_lat  (cfg_lat),
        .narrow   (req_width == pxs_pkg::BUS_8BIT),
        .err      (cfg_err)
    );
endmodule

// File: tb/sim_pxs_strobe_ctrl.sv
module sim_pxs_strobe_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_width = 2'b01, req_beats = 2'b00;
    logic [3:0] cfg_lead = '0, cfg_width = '0, cfg_lat = '0;
    logic       req_ready, port_cs, port_as, port_we, beat_o, done_o, cfg_err;
    int vectors = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pxs_strobe_ctrl u0 (.*);

    task automatic expect_bit(string req, string sig, int t, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s t=%0d actual=%b expected=%b", req, sig, t, act, exp);
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // Single transfer: checks cs, as, we, beat, done, ready against the timing rules
    task automatic run_xfer(input bit wr, input logic [1:0] wcode, input int beats_m1,
                            input int lead, input int wid, input int lat);
        int L, LB, N, tmax;
        L  = lat + 2;
        LB = (beats_m1 + 1) * L;
        N  = (wr || wcode == 2'b00) ? 5 : 2;
        tmax = (LB + N > lead + wid) ? LB + N : lead + wid;
        wait_ready();
        cfg_lead = 4'(lead); cfg_width = 4'(wid); cfg_lat = 4'(lat);
        req_write = wr; req_width = wcode; req_beats = 2'(beats_m1);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t <= tmax; t++) begin
            expect_bit("R4", "cs", t, port_cs, t < LB);
            expect_bit(wid == 0 ? "R3" : "R2", "as", t, port_as,
                       (wid != 0) && t >= lead && t < lead + wid);
            expect_bit("R6", "we", t, port_we, wr && t < LB && (t % L) != 0);
            expect_bit("R5", "beat", t, beat_o, t < LB && (t % L) == L - 1);
            expect_bit("R5", "done", t, done_o, t == LB - 1);
            if (t >= LB) expect_bit("R7", "ready", t, req_ready, t >= LB + N - 1);
            @(negedge clk);
        end
    endtask

    // Two transfers back to back with maximal strobe width and zero lead
    task automatic run_b2b(input logic [1:0] wcode, input int lat);
        int L, N, W;
        L = lat + 2;
        N = (wcode == 2'b00) ? 5 : 2;
        W = lat + ((wcode == 2'b00) ? 7 : 4);
        wait_ready();
        cfg_lead = 4'd0; cfg_width = 4'(W); cfg_lat = 4'(lat);
        req_write = 1'b0; req_width = wcode; req_beats = 2'b00;
        #1 expect_bit("R8", "err_at_limit", 0, cfg_err, 1'b0);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < L + N + W; t++) begin
            expect_bit("R9", "as", t, port_as, 1'b1);
            expect_bit("R7", "cs", t, port_cs, (t < L) || (t >= L + N && t < 2 * L + N));
            if (t == L + N) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_bit("R1", "cs", 0, port_cs, 1'b0);
        expect_bit("R1", "as", 0, port_as, 1'b0);
        expect_bit("R1", "we", 0, port_we, 1'b0);
        expect_bit("R1", "done", 0, done_o, 1'b0);
        expect_bit("R1", "beat", 0, beat_o, 1'b0);
        expect_bit("R1", "ready", 0, req_ready, 1'b1);
        expect_bit("R1", "err", 0, cfg_err, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_cfg_err();
        req_width = 2'b01; cfg_lat = 4'd0;
        cfg_lead = 4'd2; cfg_width = 4'd2; #1 expect_bit("R8", "wide_at", 0, cfg_err, 1'b0);
        cfg_width = 4'd3; #1 expect_bit("R8", "wide_over", 0, cfg_err, 1'b1);
        req_width = 2'b11; #1 expect_bit("R8", "wide64_over", 0, cfg_err, 1'b1);
        req_width = 2'b00; #1 expect_bit("R8", "narrow_ok", 0, cfg_err, 1'b0);
        cfg_lead = 4'd3; cfg_width = 4'd4; #1 expect_bit("R8", "narrow_at", 0, cfg_err, 1'b0);
        cfg_width = 4'd5; #1 expect_bit("R8", "narrow_over", 0, cfg_err, 1'b1);
        cfg_lat = 4'd1; #1 expect_bit("R8", "lat_raises", 0, cfg_err, 1'b0);
        cfg_lat = 4'd15; cfg_lead = 4'd15; cfg_width = 4'd15; req_width = 2'b10;
        #1 expect_bit("R8", "max_over", 0, cfg_err, 1'b1);
    endtask

    initial begin
        t_reset();
        run_xfer(1'b0, 2'b01, 0, 1, 3, 3);   // R2 R5 R7: 32-bit read, lead 1
        run_xfer(1'b0, 2'b10, 3, 1, 3, 1);   // R4: 4-beat 64-bit read, single strobe
        run_xfer(1'b1, 2'b00, 1, 2, 3, 2);   // R6 R7: 8-bit write, 2 beats
        run_xfer(1'b1, 2'b01, 0, 0, 2, 0);   // R6 R7: 32-bit write uses the long gap
        run_xfer(1'b0, 2'b00, 0, 0, 0, 2);   // R3 R7: strobe disabled, 8-bit read
        t_cfg_err();
        run_b2b(2'b01, 2);                   // R9 wide
        run_b2b(2'b00, 1);                   // R9 narrow
        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule